// File: doc/BRIEF.md
# Interrupt Notification Message Generator

This block tracks the level of up to twenty level-sensitive interrupt sources and converts each low-to-high transition into a single 64-bit memory write, called a notification. The write goes to a programmed target address. Its data word is a logical interrupt number, formed by adding the source index to a programmable 32-bit base. The data is placed on the bus in big-endian byte order.

Software uses an 8-byte register interface to program four things: the control word, the event-buffer base, the notification target and the logical-number base. Through the same interface it reads the per-source level word and a per-source record of sent notifications. Control bits select an unsupported delivery method, which freezes the block, and request a reset pulse for the downstream source logic. Changes to the valid flag of the event-buffer base become map and unmap requests. Notifications wait in a small in-order queue and leave on a valid/ready write channel.

Top module: `irq_notify_gen`

## Requirements
- R1: After a synchronous reset, every register reads zero, no notification is offered, and the reset, map and unmap request pulses are all low.
- R2: Registers sit at these byte offsets and keep all 64 written bits: control 0x58, event-buffer base 0x60, notification target 0x68, logical-number base 0x70. Read data is registered and is valid the cycle after the read strobe.
- R3: A read at any offset other than 0x58, 0x60, 0x68, 0x70, 0x78 or 0x80 returns all ones, and `reg_rd_err` is high in the cycle that data is valid.
- R4: The level word at 0x78 uses most-significant-bit-first numbering. Source n is bit 63-n. The bit is set by an event with level 1 and cleared by an event with level 0. Writes to 0x78 have no effect.
- R5: A rising level on source n, with bit 0 of the target register set, queues one write. Its address is the target register with bit 0 forced to 0. Its data is the 64-bit zero-extended value of (base[63:32] + n) mod 2^32, byte-reversed, so that bus bits [8k+7:8k] hold the byte for address offset k and byte 0 is the most significant.
- R6: No write is produced when bit 0 of the target register is 0, or when an event with level 1 arrives for a source that is already high.
- R7: While control bit 63 (the method bit) is set, source events leave the level word unchanged and queue nothing. `evt_err` pulses the cycle after each such event.
- R8: An event whose index is NUM_SRC or larger is rejected: the level word is unchanged, nothing is queued, and `evt_err` pulses the cycle after.
- R9: A write to the control register with bit 62 set stores the value and raises `src_reset` for exactly the one cycle after the write.
- R10: A write to the event-buffer base that takes bit 0 from 0 to 1 pulses `esb_map_req`. One that takes it from 1 to 0 pulses `esb_unmap_req`. Either pulse comes the cycle after the write, and a write that leaves bit 0 unchanged pulses neither. `esb_base` carries the register value with bit 0 cleared.
- R11: Queued writes leave in trigger order, up to FIFO_DEPTH of them. Address and data hold steady while valid is high and ready is low. A write that would overflow the queue is dropped, and `evt_err` pulses.
- R12: The status word at 0x80 sets bit 63-n when a write for source n is queued. Writing 0x80 clears the bits that are 1 in the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data |
| reg_rd_err | output | 1 | Read hit an unimplemented offset |
| evt_valid | input | 1 | Source level-change event strobe |
| evt_idx | input | IDX_W | Source index of the event |
| evt_level | input | 1 | New level of that source |
| evt_err | output | 1 | Event rejected, blocked or dropped |
| src_reset | output | 1 | Reset pulse to the source logic |
| esb_base | output | 64 | Event-buffer base, flag bit cleared |
| esb_map_req | output | 1 | Request to map the event buffer |
| esb_unmap_req | output | 1 | Request to unmap the event buffer |
| ntf_valid | output | 1 | Notification write offered |
| ntf_ready | input | 1 | Notification write accepted |
| ntf_addr | output | 64 | Notification target address |
| ntf_data | output | 64 | Big-endian logical interrupt number |

## Verification
Register read data, `reg_rd_err`, `evt_err`, `src_reset` and the map and unmap pulses all come from one register stage. The bench therefore strobes an input in one cycle and samples the matching result just after the next edge, before the pulse ends. A triggering event reaches the queue at the same edge that samples it, so `ntf_valid` rises one cycle after the strobe. The driver pushes each expected write into a scoreboard before it strobes the event. A monitor on the falling edge compares every accepted handshake against the head of that queue, and any write it did not expect counts as a miscompare.

// File: rtl/irq_notify_pkg.sv
package irq_notify_pkg;

    localparam logic [7:0] OFS_CTRL = 8'h58;
    localparam logic [7:0] OFS_ESB  = 8'h60;
    localparam logic [7:0] OFS_NTF  = 8'h68;
    localparam logic [7:0] OFS_BASE = 8'h70;
    localparam logic [7:0] OFS_LVL  = 8'h78;
    localparam logic [7:0] OFS_STAT = 8'h80;

    localparam int CTRL_METHOD_BIT = 63;
    localparam int CTRL_RESET_BIT  = 62;

    typedef struct packed {
        logic [63:0] addr;
        logic [63:0] data;
    } ntf_msg_t;

    // byte 0 of the bus word carries the most significant byte
    function automatic logic [63:0] bswap64(input logic [63:0] v);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) begin
            r[8*k +: 8] = v[8*(7-k) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_notify_regs.sv
module irq_notify_regs
    import irq_notify_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    input  logic [63:0] reg_wdata,
    input  logic [63:0] level_word,
    input  logic [63:0] stat_word,
    output logic [63:0] reg_rdata,
    output logic        reg_rd_err,
    output logic [63:0] ctrl_q,
    output logic [63:0] esb_q,
    output logic [63:0] ntf_q,
    output logic [63:0] base_q,
    output logic [63:0] stat_clr,
    output logic        src_reset,
    output logic        esb_map_req,
    output logic        esb_unmap_req
);

    assign stat_clr = (reg_wr && reg_addr == OFS_STAT) ? reg_wdata : 64'h0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q        <= '0;
            esb_q         <= '0;
            ntf_q         <= '0;
            base_q        <= '0;
            reg_rdata     <= '0;
            reg_rd_err    <= 1'b0;
            src_reset     <= 1'b0;
            esb_map_req   <= 1'b0;
            esb_unmap_req <= 1'b0;
        end else begin
            src_reset     <= 1'b0;
            esb_map_req   <= 1'b0;
            esb_unmap_req <= 1'b0;
            reg_rd_err    <= 1'b0;
            if (reg_wr) begin
                case (reg_addr)
                    OFS_CTRL: begin
                        ctrl_q    <= reg_wdata;
                        src_reset <= reg_wdata[CTRL_RESET_BIT];
                    end
                    OFS_ESB: begin
                        esb_q         <= reg_wdata;
                        esb_map_req   <= reg_wdata[0] & ~esb_q[0];
                        esb_unmap_req <= ~reg_wdata[0] & esb_q[0];
                    end
                    OFS_NTF:  ntf_q  <= reg_wdata;
                    OFS_BASE: base_q <= reg_wdata;
                    default: ;
                endcase
            end
            if (reg_rd) begin
                case (reg_addr)
                    OFS_CTRL: reg_rdata <= ctrl_q;
                    OFS_ESB:  reg_rdata <= esb_q;
                    OFS_NTF:  reg_rdata <= ntf_q;
                    OFS_BASE: reg_rdata <= base_q;
                    OFS_LVL:  reg_rdata <= level_word;
                    OFS_STAT: reg_rdata <= stat_word;
                    default: begin
                        reg_rdata  <= '1;
                        reg_rd_err <= 1'b1;
                    end
                endcase
            end
        end
    end

    // R10: a flag change is either a map or an unmap, never both
    p_map_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(esb_map_req && esb_unmap_req));

    // R9: reset pulse only follows a control write
    p_reset_src_r9: assert property (@(posedge clk) disable iff (rst)
        src_reset |-> ($past(reg_wr) && $past(reg_addr) == OFS_CTRL));

    // R3: error pulse only follows a read strobe
    p_rd_err_cause_r3: assert property (@(posedge clk) disable iff (rst)
        reg_rd_err |-> $past(reg_rd));

endmodule

// File: rtl/irq_notify_src.sv
module irq_notify_src
    import irq_notify_pkg::*;
#(
    parameter int NUM_SRC = 20,
    parameter int IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_valid,
    input  logic [IDX_W-1:0] evt_idx,
    input  logic             evt_level,
    input  logic             method,
    input  logic [63:0]      ntf_q,
    input  logic [63:0]      base_q,
    input  logic [63:0]      stat_clr,
    input  logic             fifo_full,
    output logic [63:0]      level_word,
    output logic [63:0]      stat_word,
    output logic             push,
    output ntf_msg_t         push_msg,
    output logic             evt_err
);

    logic [NUM_SRC-1:0] lvl, stat, clr_vec, evt_hot;
    logic               idx_ok, accept, was_high, want_send;
    logic [31:0]        lisn;

    for (genvar g = 0; g < 64; g++) begin : g_map
        if (g < NUM_SRC) begin : g_used
            assign level_word[63-g] = lvl[g];
            assign stat_word[63-g]  = stat[g];
            assign clr_vec[g]       = stat_clr[63-g];
        end else begin : g_pad
            assign level_word[63-g] = 1'b0;
            assign stat_word[63-g]  = 1'b0;
        end
    end

    always_comb begin
        idx_ok    = 32'(evt_idx) < NUM_SRC;
        evt_hot   = idx_ok ? (NUM_SRC'(1) << evt_idx) : '0;
        accept    = evt_valid && idx_ok && !method;
        was_high  = |(lvl & evt_hot);
        want_send = accept && evt_level && !was_high && ntf_q[0];
        push      = want_send && !fifo_full;
        lisn      = base_q[63:32] + 32'(evt_idx);
        push_msg.addr = {ntf_q[63:1], 1'b0};
        push_msg.data = bswap64({32'h0, lisn});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl     <= '0;
            stat    <= '0;
            evt_err <= 1'b0;
        end else begin
            if (accept) begin
                lvl <= evt_level ? (lvl | evt_hot) : (lvl & ~evt_hot);
            end
            stat    <= (stat & ~clr_vec) | (push ? evt_hot : '0);
            evt_err <= evt_valid && (!idx_ok || method || (want_send && fifo_full));
        end
    end

    // R7: method bit freezes the level word
    p_method_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && method) |=> $stable(level_word));

    // R8: out-of-range index always flagged
    p_bad_idx_r8: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && 32'(evt_idx) >= NUM_SRC) |=> evt_err);

    // R4: accepted event leaves its source at the event level
    p_level_follow_r4: assert property (@(posedge clk) disable iff (rst)
        accept |=> ((|(lvl & $past(evt_hot))) == $past(evt_level)));

endmodule

// File: rtl/irq_notify_fifo.sv
module irq_notify_fifo
    import irq_notify_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  ntf_msg_t push_msg,
    output logic     full,
    output logic     out_valid,
    input  logic     out_ready,
    output ntf_msg_t out_msg
);

    ntf_msg_t         mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             pop;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (count == CNT_W'(DEPTH));
    assign out_valid = (count != '0);
    assign out_msg   = mem[rptr];
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_msg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= nxt(wptr);
            if (pop)  rptr <= nxt(rptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // R11: offered write holds while stalled
    p_hold_stall_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_msg)));

    // R11: queue never written past its depth
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);

    p_count_bound_r11: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

endmodule

// File: rtl/irq_notify_gen.sv
module irq_notify_gen
    import irq_notify_pkg::*;
#(
    parameter int NUM_SRC    = 20,
    parameter int FIFO_DEPTH = 4,
    localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_addr,
    input  logic [63:0]      reg_wdata,
    output logic [63:0]      reg_rdata,
    output logic             reg_rd_err,
    input  logic             evt_valid,
    input  logic [IDX_W-1:0] evt_idx,
    input  logic             evt_level,
    output logic             evt_err,
    output logic             src_reset,
    output logic [63:0]      esb_base,
    output logic             esb_map_req,
    output logic             esb_unmap_req,
    output logic             ntf_valid,
    input  logic             ntf_ready,
    output logic [63:0]      ntf_addr,
    output logic [63:0]      ntf_data
);

    logic [63:0] ctrl_q, esb_q, ntf_q, base_q, stat_clr, level_word, stat_word;
    logic        push, fifo_full;
    ntf_msg_t    push_msg, out_msg;

    irq_notify_regs i_regs (
        .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
        .level_word, .stat_word, .reg_rdata, .reg_rd_err,
        .ctrl_q, .esb_q, .ntf_q, .base_q, .stat_clr,
        .src_reset, .esb_map_req, .esb_unmap_req
    );

    irq_notify_src #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) i_src (
        .clk, .rst, .evt_valid, .evt_idx, .evt_level,
        .method(ctrl_q[CTRL_METHOD_BIT]), .ntf_q, .base_q, .stat_clr,
        .fifo_full, .level_word, .stat_word, .push, .push_msg, .evt_err
    );

    irq_notify_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk, .rst, .push, .push_msg, .full(fifo_full),
        .out_valid(ntf_valid), .out_ready(ntf_ready), .out_msg
    );

    assign esb_base = {esb_q[63:1], 1'b0};
    assign ntf_addr = out_msg.addr;
    assign ntf_data = out_msg.data;

    // R5: offered target never carries the valid flag
    p_addr_clean_r5: assert property (@(posedge clk) disable iff (rst)
        ntf_valid |-> !ntf_addr[0]);

endmodule

// File: tb/test_irq_notify_gen.sv
module test_irq_notify_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        reg_rd_err;
    logic        evt_valid = 1'b0;
    logic [4:0]  evt_idx = '0;
    logic        evt_level = 1'b0;
    logic        evt_err, src_reset, esb_map_req, esb_unmap_req;
    logic [63:0] esb_base, ntf_addr, ntf_data;
    logic        ntf_valid;
    logic        ntf_ready = 1'b1;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [127:0] expq [$];

    always #10 clk = ~clk;

    irq_notify_gen i_irq_notify_gen (
        .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
        .reg_rd_err, .evt_valid, .evt_idx, .evt_level, .evt_err, .src_reset,
        .esb_base, .esb_map_req, .esb_unmap_req, .ntf_valid, .ntf_ready,
        .ntf_addr, .ntf_data
    );

    function automatic logic [63:0] swap8(input logic [63:0] v);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[63-8*k -: 8] = v[8*k +: 8];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d, output logic e);
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); #1;
        reg_rd = 1'b0;
        d = reg_rdata; e = reg_rd_err;
    endtask

    task automatic evt(input int idx, input logic lv, output logic e);
        @(posedge clk); #1;
        evt_valid = 1'b1; evt_idx = 5'(idx); evt_level = lv;
        @(posedge clk); #1;
        evt_valid = 1'b0;
        e = evt_err;
    endtask

    task automatic expect_ntf(input logic [63:0] a, input logic [31:0] lisn);
        expq.push_back({a, swap8({32'h0, lisn})});
    endtask

    // scoreboard monitor: handshake completes at the following edge
    always @(negedge clk) begin
        if (!rst && ntf_valid && ntf_ready) begin
            if (expq.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R6: unexpected write actual %h/%h expected none", ntf_addr, ntf_data);
            end else begin
                logic [127:0] e;
                e = expq.pop_front();
                check("R5 addr", ntf_addr, e[127:64]);
                check("R5/R11 data", ntf_data, e[63:0]);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic e;
        logic [63:0] lvl_exp;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check("R1 ntf_valid", 64'(ntf_valid), 0);
        check("R1 pulses", {61'h0, src_reset, esb_map_req, esb_unmap_req}, 0);
        rd(8'h58, d, e); check("R1 ctrl", d, 0);
        rd(8'h60, d, e); check("R1 esb", d, 0);
        rd(8'h68, d, e); check("R1 ntf", d, 0);
        rd(8'h70, d, e); check("R1 base", d, 0);
        rd(8'h78, d, e); check("R1 level", d, 0);
        rd(8'h80, d, e); check("R1 status", d, 0);

        // R2 read-back
        wr(8'h70, 64'hA5A5_0F0F_1234_5678);
        rd(8'h70, d, e); check("R2 base", d, 64'hA5A5_0F0F_1234_5678);
        check("R2 no err", 64'(e), 0);
        wr(8'h68, 64'hFFFF_0000_FFFF_0000);
        rd(8'h68, d, e); check("R2 ntf", d, 64'hFFFF_0000_FFFF_0000);

        // R3 unimplemented reads
        rd(8'h50, d, e); check("R3 data", d, '1); check("R3 err", 64'(e), 1);
        rd(8'h88, d, e); check("R3 data", d, '1); check("R3 err", 64'(e), 1);

        // R10 event-buffer base flag
        wr(8'h60, 64'h0000_0060_3000_0001);
        check("R10 map", 64'(esb_map_req), 1); check("R10 unmap", 64'(esb_unmap_req), 0);
        check("R10 base", esb_base, 64'h0000_0060_3000_0000);
        wr(8'h60, 64'h0000_0060_4000_0001);
        check("R10 no map", {62'h0, esb_map_req, esb_unmap_req}, 0);
        wr(8'h60, 64'h0000_0060_4000_0000);
        check("R10 unmap", 64'(esb_unmap_req), 1); check("R10 map", 64'(esb_map_req), 0);

        // R9 source reset pulse
        wr(8'h58, 64'h4000_0000_0000_00C3);
        check("R9 pulse", 64'(src_reset), 1);
        @(posedge clk); #1;
        check("R9 one cycle", 64'(src_reset), 0);
        rd(8'h58, d, e); check("R9 stored", d, 64'h4000_0000_0000_00C3);
        wr(8'h58, 64'h0);

        // R6 flag clear: level tracked, no write
        wr(8'h68, 64'h0000_0000_8000_1230);
        wr(8'h70, 64'h0000_0100_DEAD_BEEF);
        evt(3, 1'b1, e); check("R6 err", 64'(e), 0);
        rd(8'h78, d, e); check("R4 level set", d, 64'h1 << 60);
        evt(3, 1'b0, e);
        rd(8'h78, d, e); check("R4 level clear", d, 0);

        // R5 notifications
        wr(8'h68, 64'h0000_0000_8000_1231);
        expect_ntf(64'h8000_1230, 32'h103);
        evt(3, 1'b1, e); check("R5 err", 64'(e), 0);
        evt(3, 1'b1, e);                       // R6 already high
        expect_ntf(64'h8000_1230, 32'h113);
        evt(19, 1'b1, e);
        lvl_exp = (64'h1 << 60) | (64'h1 << 44);
        rd(8'h78, d, e); check("R4 level", d, lvl_exp);
        wr(8'h70, 64'hFFFF_FFFE_0000_0000);
        expect_ntf(64'h8000_1230, 32'h3);      // R5 wrap mod 2^32
        evt(5, 1'b1, e);
        lvl_exp |= 64'h1 << 58;

        // R7 method bit
        wr(8'h58, 64'h8000_0000_0000_0000);
        evt(7, 1'b1, e); check("R7 err", 64'(e), 1);
        rd(8'h78, d, e); check("R7 level frozen", d, lvl_exp);
        wr(8'h58, 64'h0);

        // R8 index out of range
        evt(25, 1'b1, e); check("R8 err", 64'(e), 1);
        evt(20, 1'b1, e); check("R8 err edge", 64'(e), 1);
        rd(8'h78, d, e); check("R8 level", d, lvl_exp);

        // R4 write to level ignored
        wr(8'h78, '1);
        rd(8'h78, d, e); check("R4 write ignored", d, lvl_exp);

        // R12 status
        rd(8'h80, d, e); check("R12 status", d, lvl_exp);
        wr(8'h80, 64'h1 << 60);
        rd(8'h80, d, e); check("R12 clear", d, (64'h1 << 58) | (64'h1 << 44));

        // R11 queue order and overflow
        @(posedge clk); #1 ntf_ready = 1'b0;
        for (int i = 10; i < 14; i++) begin
            expect_ntf(64'h8000_1230, 32'(i - 2));
            evt(i, 1'b1, e); check("R11 queued", 64'(e), 0);
        end
        evt(14, 1'b1, e); check("R11 overflow err", 64'(e), 1);
        repeat (3) @(posedge clk);
        #1 check("R11 held valid", 64'(ntf_valid), 1);
        check("R11 held data", ntf_data, swap8(64'h8));
        ntf_ready = 1'b1;
        repeat (12) @(posedge clk);
        #1 check("R6/R11 drained", 64'(expq.size()), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule